// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable binary counter built from identical small stages. Each stage holds a 4-bit count that changes only on the rising clock edge. At that edge it loads a parallel word, holds, or steps up or down by one. Two active-low count enables must both be asserted for a step to happen. An active-low up/down level chooses the direction.

Each stage produces an active-low carry. The carry is asserted when the stage sits at its terminal value for the current direction and its second enable is asserted. The terminal value is all ones when counting up and all zeros when counting down. The first enable has no part in the carry.

Feeding each stage's carry into the second enable of the next stage turns several stages into one wide synchronous counter with no extra gating. The top module is that chain. Its shared load, first enable and direction reach every stage. Its second enable drives only the lowest stage.

Top module: `ud_count_chain`

## Requirements
- R1: When loadN is low at a rising edge, the count takes dataIn at that edge. This holds whatever the enables and upDn are.
- R2: With loadN high, the count holds at the edge if enPN or enTN is high.
- R3: With loadN high, enPN low, enTN low and upDn high (1 = up), the count increments by one at the edge.
- R4: With loadN high, both enables low and upDn low (0 = down), the count decrements by one at the edge.
- R5: Counting wraps modulo 2^width. All ones goes to zero when counting up, and zero goes to all ones when counting down.
- R6: rcoN is combinational and low exactly when enTN is low and the count is at its terminal value. The terminal value is all ones when upDn is high and zero when upDn is low. enPN has no effect on rcoN.
- R7: In the chain, stage i>0 takes its enTN from the rcoN of stage i-1. The joined count (stage 0 in the low bits) behaves as one STAGES*STAGE_W-bit counter under R1 to R6.
- R8: Levels that loadN, enPN, enTN, upDn and dataIn hold between edges and then withdraw before the edge have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| loadN | input | 1 | Synchronous parallel load, active low |
| enPN | input | 1 | Count enable that does not gate the carry, active low, shared by all stages |
| enTN | input | 1 | Count enable that also gates the carry, active low, drives stage 0 |
| upDn | input | 1 | Direction, 1 = up, 0 = down |
| dataIn | input | STAGES*STAGE_W | Parallel load word |
| count | output | STAGES*STAGE_W | Joined count, stage 0 in the low bits |
| rcoN | output | 1 | Carry of the top stage, active low |

## Verification
A load and a terminal-count carry can land in the same cycle. The bench sets the full count to all ones with both enables low, so the carry is asserted and a wrap is pending. It then pulls loadN low in that same cycle. It judges that the carry is low before the edge and that the loaded word, not the wrapped value, appears after it. A second collision flips direction while the count sits at a terminal value. The bench checks that the carry follows upDn at once and that the next edge steps the count in the new direction.

// File: rtl/ud_count_pkg.sv
package ud_count_pkg;
  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
  } strobe_t;
endpackage

// File: rtl/ud_count_ctrl.sv
module ud_count_ctrl
  import ud_count_pkg::*;
(
  input  logic    clk,
  input  logic    loadN,
  input  logic    enPN,
  input  logic    enTN,
  input  logic    upDn,
  input  logic    atMax,
  input  logic    atMin,
  output strobe_t strb,
  output logic    rcoN
);
  logic stepOk;

  always_comb begin
    stepOk    = loadN && !enPN && !enTN;
    strb.load = !loadN;
    strb.inc  = stepOk && upDn;
    strb.dec  = stepOk && !upDn;
    rcoN      = !(!enTN && (upDn ? atMax : atMin));
  end

  // R1: load excludes stepping
  assert_load_priority_R1: assert property (@(posedge clk)
    $onehot0({strb.load, strb.inc, strb.dec}))
    else $error("load priority broken");

  // R6: carry only while the gating enable is asserted
  assert_rco_gate_R6: assert property (@(posedge clk)
    !rcoN |-> !enTN)
    else $error("carry without enable T");
endmodule

// File: rtl/ud_count_dp.sv
module ud_count_dp
  import ud_count_pkg::*;
#(
  parameter int STAGE_W = 4
) (
  input  logic               clk,
  input  strobe_t            strb,
  input  logic [STAGE_W-1:0] dataIn,
  output logic [STAGE_W-1:0] cntQ,
  output logic               atMax,
  output logic               atMin
);
  localparam logic [STAGE_W-1:0] ONE = STAGE_W'(1);

  always_ff @(posedge clk) begin
    if (strb.load)     cntQ <= dataIn;
    else if (strb.inc) cntQ <= cntQ + ONE;
    else if (strb.dec) cntQ <= cntQ - ONE;
  end

  always_comb begin
    atMax = &cntQ;
    atMin = ~|cntQ;
  end

  assert_load_R1: assert property (@(posedge clk) disable iff ($isunknown(cntQ))
    strb.load |=> cntQ == $past(dataIn))
    else $error("load value wrong");

  assert_hold_R2: assert property (@(posedge clk) disable iff ($isunknown(cntQ))
    !strb.load && !strb.inc && !strb.dec |=> $stable(cntQ))
    else $error("hold broken");

  assert_inc_R3: assert property (@(posedge clk) disable iff ($isunknown(cntQ))
    !strb.load && strb.inc |=> cntQ == STAGE_W'($past(cntQ) + ONE))
    else $error("increment wrong");

  assert_dec_R4: assert property (@(posedge clk) disable iff ($isunknown(cntQ))
    !strb.load && strb.dec |=> cntQ == STAGE_W'($past(cntQ) - ONE))
    else $error("decrement wrong");

  // R5: wrap points
  assert_wrap_up_R5: assert property (@(posedge clk) disable iff ($isunknown(cntQ))
    !strb.load && strb.inc && atMax |=> atMin)
    else $error("up wrap wrong");
endmodule

// File: rtl/ud_count_stage.sv
module ud_count_stage
  import ud_count_pkg::*;
#(
  parameter int STAGE_W = 4
) (
  input  logic               clk,
  input  logic               loadN,
  input  logic               enPN,
  input  logic               enTN,
  input  logic               upDn,
  input  logic [STAGE_W-1:0] dataIn,
  output logic [STAGE_W-1:0] count,
  output logic               rcoN
);
  strobe_t strb;
  logic    atMax;
  logic    atMin;

  ud_count_ctrl ctrl_i (
    .clk   (clk),
    .loadN (loadN),
    .enPN  (enPN),
    .enTN  (enTN),
    .upDn  (upDn),
    .atMax (atMax),
    .atMin (atMin),
    .strb  (strb),
    .rcoN  (rcoN)
  );

  ud_count_dp #(.STAGE_W(STAGE_W)) dp_i (
    .clk    (clk),
    .strb   (strb),
    .dataIn (dataIn),
    .cntQ   (count),
    .atMax  (atMax),
    .atMin  (atMin)
  );
endmodule

// File: rtl/ud_count_chain.sv
module ud_count_chain #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 3
) (
  input  logic                       clk,
  input  logic                       loadN,
  input  logic                       enPN,
  input  logic                       enTN,
  input  logic                       upDn,
  input  logic [STAGES*STAGE_W-1:0]  dataIn,
  output logic [STAGES*STAGE_W-1:0]  count,
  output logic                       rcoN
);
  localparam int CHAIN_W = STAGES * STAGE_W;

  logic [STAGES:0] carryN;

  assign carryN[0] = enTN;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    ud_count_stage #(.STAGE_W(STAGE_W)) stage_i (
      .clk    (clk),
      .loadN  (loadN),
      .enPN   (enPN),
      .enTN   (carryN[i]),
      .upDn   (upDn),
      .dataIn (dataIn[i*STAGE_W +: STAGE_W]),
      .count  (count[i*STAGE_W +: STAGE_W]),
      .rcoN   (carryN[i+1])
    );
  end

  assign rcoN = carryN[STAGES];

  assert_chain_up_R7: assert property (@(posedge clk) disable iff ($isunknown(count))
    loadN && !enPN && !enTN && upDn |=> count == CHAIN_W'($past(count) + 1'b1))
    else $error("chain increment wrong");

  assert_chain_down_R7: assert property (@(posedge clk) disable iff ($isunknown(count))
    loadN && !enPN && !enTN && !upDn |=> count == CHAIN_W'($past(count) - 1'b1))
    else $error("chain decrement wrong");
endmodule

// File: tb/ud_count_chain_tb.sv
module ud_count_chain_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int NVEC = 15;

  typedef struct packed {
    logic         l;
    logic         p;
    logic         t;
    logic         u;
    logic [W-1:0] d;
    logic         rco;   // expected carry with these inputs, before the edge
    logic [W-1:0] cnt;   // expected count after the edge
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 12'hFFE, 1'b1, 12'hFFE}, // R1 load
    '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 1'b1, 12'hFFF}, // R3
    '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 1'b0, 12'h000}, // R5 up wrap, R6
    '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'hFFF}, // R5 down wrap, R6
    '{1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 1'b1, 12'hFFF}, // R2 P high
    '{1'b1, 1'b1, 1'b0, 1'b1, 12'h000, 1'b0, 12'hFFF}, // R6 P no effect, R2
    '{1'b1, 1'b0, 1'b1, 1'b1, 12'h000, 1'b1, 12'hFFF}, // R2 T high
    '{1'b0, 1'b0, 1'b0, 1'b1, 12'h00F, 1'b0, 12'h00F}, // R1 load vs carry
    '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 1'b1, 12'h010}, // R7 carry up
    '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 1'b1, 12'h00F}, // R7 borrow down
    '{1'b0, 1'b1, 1'b1, 1'b0, 12'h000, 1'b1, 12'h000}, // R1
    '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0, 12'hFFF}, // R4 R5
    '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 1'b0, 12'h000}, // direction flip at terminal
    '{1'b0, 1'b0, 1'b0, 1'b0, 12'h5A3, 1'b0, 12'h5A3}, // R1
    '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 1'b1, 12'h5A2}  // R4
  };

  logic         clk = 1'b0;
  logic         loadN = 1'b1, enPN = 1'b1, enTN = 1'b1, upDn = 1'b1;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] count;
  logic         rcoN;
  int           nRun = 0;
  int           nFail = 0;
  logic [W-1:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  ud_count_chain #(.STAGE_W(4), .STAGES(3)) dut_i (
    .clk(clk), .loadN(loadN), .enPN(enPN), .enTN(enTN), .upDn(upDn),
    .dataIn(dataIn), .count(count), .rcoN(rcoN)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic p, input logic t, input logic u,
                       input logic [W-1:0] d);
    @(negedge clk);
    loadN = l; enPN = p; enTN = t; upDn = u; dataIn = d;
    #1;
  endtask

  function automatic logic modelRco(input logic [W-1:0] c, input logic t, input logic u);
    return !(!t && (u ? (c == '1) : (c == '0)));
  endfunction

  task automatic stepModel(input string req);
    logic expR;
    expR = modelRco(model, enTN, upDn);
    check(rcoN == expR, {req, " R6 carry"}, W'(rcoN), W'(expR));
    if (!loadN) model = dataIn;
    else if (!enPN && !enTN) model = upDn ? model + 1'b1 : model - 1'b1;
    @(posedge clk); #1;
    check(count == model, req, count, model);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=%h expected=%h", count, model);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].l, VEC[i].p, VEC[i].t, VEC[i].u, VEC[i].d);
      check(rcoN == VEC[i].rco, $sformatf("R6 vector %0d carry", i), W'(rcoN), W'(VEC[i].rco));
      @(posedge clk); #1;
      check(count == VEC[i].cnt, $sformatf("R1-R5 vector %0d count", i), count, VEC[i].cnt);
    end

    // R8: transient levels withdrawn before the edge
    drive(1'b0, 1'b1, 1'b1, 1'b1, 12'h100);
    @(posedge clk); #1;
    drive(1'b1, 1'b0, 1'b0, 1'b1, 12'h000);
    #1 loadN = 1'b0; dataIn = 12'hABC; enPN = 1'b1; upDn = 1'b0;
    #1 loadN = 1'b1; dataIn = 12'h000; enPN = 1'b0; upDn = 1'b1;
    @(posedge clk); #1;
    check(count == 12'h101, "R8 glitch ignored", count, 12'h101);

    // R7 R5: full-range up run with reference model
    drive(1'b0, 1'b0, 1'b0, 1'b1, 12'h000);
    model = count;
    stepModel("R1 chain load");
    for (int k = 0; k < 4100; k++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b1, 12'h000);
      stepModel("R7 chain up");
    end
    for (int k = 0; k < 40; k++) begin
      drive(1'b1, k % 5 == 0, 1'b0, 1'b0, 12'h000);
      stepModel("R7 chain down");
    end
    // R2 via T hold while P low
    drive(1'b1, 1'b0, 1'b1, 1'b0, 12'h000);
    stepModel("R2 chain hold");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule